// File: doc/BRIEF.md
# Shadowed PWM Channel with Clock Prescaler

This block produces one pulse-width-modulated output. A 16-bit prescaler first halves the system clock and then divides it by the programmed value plus one. Each resulting tick advances an 8-bit count. The output is at its active level while the count is below the programmed width. When the count reaches the programmed period, the count returns to zero and a new pulse begins.

Software writes the prescaler, width and period through a one-cycle write port. Each write lands in a staged copy. The working copies used by the comparators and the divider take the staged values together at two moments: when the channel is switched on, and at each period boundary. A running waveform therefore never shows a half-updated setting. The output polarity can be inverted.

A controller with four states sequences the channel:
- **S_OFF**: disabled, with the count and divider cleared.
- **S_PULSE**: count below width, output active.
- **S_REST**: count at or above width, output inactive.
- **S_HALT**: working period is zero, output held inactive.

The transitions are:
- **enable** (S_OFF to a running state): loads the staged values.
- **advance** (S_PULSE to S_REST, or staying in the same state): a tick increments the count.
- **wrap** (period boundary, from S_PULSE or S_REST): a tick at count equal to period reloads the staged values and clears the count.
- **retry** (S_HALT): each tick reloads the staged values.
- **disable** (any state to S_OFF): taken when `chan_en` is low.

Top module: `pwm_shadowed`

## Requirements
- R1: While `chan_en` is low, `pwm_out` sits at its inactive level (0 when `invert` is 0, 1 when `invert` is 1) and the count and divider are held at zero, so the first pulse after enabling has full length.
- R2: The count advances once every 2×(P+1) clock cycles, where P is the working prescaler value. P = 0 gives one advance every 2 cycles.
- R3: The output is active while count < working width and inactive once count ≥ width.
- R4: A tick taken while count equals the working period sets the count to 0 and starts a new pulse, so one period lasts (period+1) ticks.
- R5: Raising `chan_en` copies the staged prescaler, width and period into the working copies, with the count and divider starting from zero.
- R6: Writes made while running change the staged copies only. All three working values take the staged values together at the next period boundary.
- R7: With `invert` = 1, the output is low during the pulse and high for the rest of the period.
- R8: A working period of 0 keeps the count at 0 and the output inactive. Each tick reloads the staged values, so a later nonzero period restarts the waveform.
- R9: A working width of 0 keeps the output inactive for the whole period.
- R10: `wr_sel` encoding: 0 writes the prescaler (all 16 bits of `wr_data`), 1 writes the width (`wr_data[7:0]`), 2 writes the period (`wr_data[7:0]`). A write with `wr_sel` = 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe for a staged register |
| wr_sel | input | 2 | Register select: 0 prescaler, 1 width, 2 period, 3 none |
| wr_data | input | 16 | Write data |
| chan_en | input | 1 | Channel enable |
| invert | input | 1 | Output polarity: 1 inverts the output |
| pwm_out | output | 1 | PWM output |

## Verification
A wrong divider phase or a wrong count shows at `pwm_out` as an edge shifted by at least one clock. The bench compares the output against a tick-level reference in every cycle, so such an error is reported within one prescaled tick. A working copy reloaded too early or too late shows as a mid-period change of duty or period. That becomes visible no later than the first width or period compare after the write, which is at most one period. A controller stuck in S_HALT or S_OFF shows as a flat output where the reference expects a pulse, within one period of the cause.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic [1:0] {
        S_OFF   = 2'd0,
        S_PULSE = 2'd1,
        S_REST  = 2'd2,
        S_HALT  = 2'd3
    } pwm_state_t;

    localparam logic [1:0] SEL_PRE = 2'd0;
    localparam logic [1:0] SEL_WID = 2'd1;
    localparam logic [1:0] SEL_PER = 2'd2;
endpackage

// File: rtl/pwm_div.sv
module pwm_div #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);
    logic             half_q;
    logic [PRE_W-1:0] pcnt_q;

    // Fixed divide-by-two stage, then the programmable divide by pre+1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            pcnt_q <= '0;
        end else if (!active) begin
            half_q <= 1'b0;
            pcnt_q <= '0;
        end else if (half_q) begin
            half_q <= 1'b0;
            pcnt_q <= (pcnt_q == pre) ? '0 : pcnt_q + 1'b1;
        end else begin
            half_q <= 1'b1;
        end
    end

    always_comb tick = active && half_q && (pcnt_q == pre);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
    AST_DIV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (pcnt_q == '0) && !half_q); // R1
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
    parameter int PRE_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [PRE_W-1:0] wr_data,
    input  logic             load,
    output logic [CNT_W-1:0] stg_wid,
    output logic [CNT_W-1:0] stg_per,
    output logic [PRE_W-1:0] work_pre,
    output logic [CNT_W-1:0] work_wid,
    output logic [CNT_W-1:0] work_per
);
    import pwm_pkg::*;

    logic [PRE_W-1:0] stg_pre;

    // Staged copies, written by software at any time.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_pre <= '0;
            stg_wid <= '0;
            stg_per <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_PRE: stg_pre <= wr_data;
                SEL_WID: stg_wid <= wr_data[CNT_W-1:0];
                SEL_PER: stg_per <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Working copies, all three taken together on a load pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_pre <= '0;
            work_wid <= '0;
            work_per <= '0;
        end else if (load) begin
            work_pre <= stg_pre;
            work_wid <= stg_wid;
            work_per <= stg_per;
        end
    end

    AST_WORK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(work_pre) && $stable(work_wid) && $stable(work_per)); // R6
    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (work_wid == $past(stg_wid)) && (work_per == $past(stg_per))); // R5
endmodule

// File: rtl/pwm_fsm.sv
module pwm_fsm #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             invert,
    input  logic             tick,
    input  logic [CNT_W-1:0] stg_wid,
    input  logic [CNT_W-1:0] stg_per,
    input  logic [CNT_W-1:0] work_wid,
    input  logic [CNT_W-1:0] work_per,
    output logic             active,
    output logic             load,
    output logic             pwm_out
);
    import pwm_pkg::*;

    pwm_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   cnt_inc;
    logic             at_end;

    function automatic pwm_state_t pick(input logic [CNT_W-1:0] wid,
                                        input logic [CNT_W-1:0] per,
                                        input logic [CNT_W:0]   c);
        if (per == '0)
            return S_HALT;
        else if (c < {1'b0, wid})
            return S_PULSE;
        else
            return S_REST;
    endfunction

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        at_end  = (cnt_q == work_per);
        state_d = state_q;
        cnt_d   = cnt_q;
        load    = 1'b0;
        if (!chan_en) begin
            state_d = S_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                S_OFF: begin
                    load    = 1'b1;
                    cnt_d   = '0;
                    state_d = pick(stg_wid, stg_per, '0);
                end
                S_PULSE, S_REST: begin
                    if (tick) begin
                        if (at_end) begin
                            load    = 1'b1;
                            cnt_d   = '0;
                            state_d = pick(stg_wid, stg_per, '0);
                        end else begin
                            cnt_d   = cnt_inc[CNT_W-1:0];
                            state_d = pick(work_wid, work_per, cnt_inc);
                        end
                    end
                end
                S_HALT: begin
                    cnt_d = '0;
                    if (tick) begin
                        load    = 1'b1;
                        state_d = pick(stg_wid, stg_per, '0);
                    end
                end
                default: state_d = S_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        active  = (state_q != S_OFF);
        pwm_out = (state_q == S_PULSE) ^ invert;
    end

    AST_OFF_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (state_q == S_OFF) && (cnt_q == '0)); // R1
    AST_PULSE_BELOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PULSE) |-> (cnt_q < work_wid)); // R3
    AST_REST_AT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_REST) |-> (cnt_q >= work_wid)); // R3
    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PULSE || state_q == S_REST) |-> (cnt_q <= work_per)); // R4
    AST_HALT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALT) |-> (cnt_q == '0) && (work_per == '0)); // R8
    AST_CNT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && !tick && state_q != S_OFF) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/pwm_shadowed.sv
module pwm_shadowed #(
    parameter int PRE_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [PRE_W-1:0] wr_data,
    input  logic             chan_en,
    input  logic             invert,
    output logic             pwm_out
);
    logic             tick, active, load;
    logic [CNT_W-1:0] stg_wid, stg_per, work_wid, work_per;
    logic [PRE_W-1:0] work_pre;

    pwm_shadow #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .load(load),
        .stg_wid(stg_wid), .stg_per(stg_per),
        .work_pre(work_pre), .work_wid(work_wid), .work_per(work_per)
    );

    pwm_div #(.PRE_W(PRE_W)) u_div (
        .clk(clk), .rst_n(rst_n), .active(active), .pre(work_pre), .tick(tick)
    );

    pwm_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .invert(invert),
        .tick(tick), .stg_wid(stg_wid), .stg_per(stg_per),
        .work_wid(work_wid), .work_per(work_per),
        .active(active), .load(load), .pwm_out(pwm_out)
    );

    AST_DISABLED_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (pwm_out == invert)); // R1 R7
endmodule

// File: tb/sim_pwm_shadowed.sv
module sim_pwm_shadowed;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        chan_en = 1'b0;
    logic        invert = 1'b0;
    logic        pwm_out;

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference model state, kept in ticks rather than in controller states.
    int m_sp = 0, m_sw = 0, m_st = 0;
    int m_p = 0, m_w = 0, m_t = 0;
    int m_cnt = 0, m_div = 0;
    bit m_on = 1'b0;
    bit exp_q[$];

    always #4 clk = ~clk;   // 125 MHz

    pwm_shadowed u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .chan_en(chan_en), .invert(invert), .pwm_out(pwm_out)
    );

    // Model: pushes the expected active/inactive level for every cycle.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sp = 0; m_sw = 0; m_st = 0; m_p = 0; m_w = 0; m_t = 0;
            m_cnt = 0; m_div = 0; m_on = 1'b0;
            exp_q.delete();
        end else begin
            if (!chan_en) begin
                m_on = 1'b0; m_cnt = 0; m_div = 0;
            end else if (!m_on) begin
                m_on = 1'b1; m_p = m_sp; m_w = m_sw; m_t = m_st;   // R5
                m_cnt = 0; m_div = 0;
            end else if (m_div == 2 * m_p + 1) begin               // R2
                m_div = 0;
                if (m_t == 0 || m_cnt == m_t) begin                  // R4 R6 R8
                    m_cnt = 0; m_p = m_sp; m_w = m_sw; m_t = m_st;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end else begin
                m_div = m_div + 1;
            end
            if (wr_en) begin                                         // R10
                case (wr_sel)
                    2'd0: m_sp = int'(wr_data);
                    2'd1: m_sw = int'(wr_data[7:0]);
                    2'd2: m_st = int'(wr_data[7:0]);
                    default: ;
                endcase
            end
            exp_q.push_back(m_on && (m_t != 0) && (m_cnt < m_w)); // R3 R9
        end
    end

    // Monitor: compares in the middle of each cycle.
    always @(negedge clk) begin
        if (!done) begin
            bit act, exp_lvl;
            if (!rst_n) begin
                exp_lvl = invert;
            end else if (exp_q.size() == 0) begin
                exp_lvl = invert;
            end else begin
                act = exp_q.pop_front();
                exp_lvl = act ^ invert;                             // R7
            end
            n_run++;
            if (pwm_out !== exp_lvl) begin
                n_fail++;
                $display("FAIL %s t=%0t pwm_out=%b expected=%b", cur_req, $time, pwm_out, exp_lvl);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        wait_cyc(1);
        wr_en = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired in %s", cur_req);
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset and disabled levels
        #10;
        n_run++;
        if (pwm_out !== 1'b0) begin
            n_fail++; $display("FAIL R1 reset pwm_out=%b expected=0", pwm_out);
        end
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(3);
        invert = 1'b1; #1;
        n_run++;
        if (pwm_out !== 1'b1) begin
            n_fail++; $display("FAIL R1 disabled inverted pwm_out=%b expected=1", pwm_out);
        end
        wait_cyc(1);
        invert = 1'b0;

        // R10 R5 R2 R3 R4: fastest prescaler, width 3, period 7
        cur_req = "R10";
        wr(2'd0, 16'd0); wr(2'd1, 16'd3); wr(2'd2, 16'd7);
        wait_cyc(2);
        cur_req = "R5";
        chan_en = 1'b1;
        wait_cyc(20);
        cur_req = "R3";
        wait_cyc(60);

        // R6: change all three mid-period
        cur_req = "R6";
        wait_cyc(5);
        wr(2'd0, 16'd1); wr(2'd1, 16'd5); wr(2'd2, 16'd9);
        wait_cyc(200);

        // R2: slower prescaler
        cur_req = "R2";
        wr(2'd0, 16'd4);
        wait_cyc(300);

        // R7: inverted polarity while running
        cur_req = "R7";
        invert = 1'b1;
        wait_cyc(200);
        invert = 1'b0;

        // R10: select 3 must leave every setting alone
        cur_req = "R10";
        wr(2'd3, 16'h0001);
        wait_cyc(200);

        // R9: width zero
        cur_req = "R9";
        wr(2'd0, 16'd0); wr(2'd1, 16'd0);
        wait_cyc(100);

        // R4: width above period keeps output active all period
        cur_req = "R4";
        wr(2'd1, 16'd200); wr(2'd2, 16'd5);
        wait_cyc(100);

        // R8: zero period, then recovery
        cur_req = "R8";
        wr(2'd2, 16'd0);
        wait_cyc(80);
        wr(2'd1, 16'd2); wr(2'd2, 16'd4);
        wait_cyc(100);

        // R1: disable mid-run and restart
        cur_req = "R1";
        wait_cyc(3);
        chan_en = 1'b0;
        wait_cyc(20);
        wr(2'd0, 16'd2); wr(2'd1, 16'd1); wr(2'd2, 16'd3);
        cur_req = "R5";
        chan_en = 1'b1;
        wait_cyc(150);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule